// File: doc/BRIEF.md
# Multi-segment address translator

This block turns a 16-bit virtual address into a 16-bit physical address through a four-entry segment table held in flip-flops. The two most significant address bits pick a table entry. The remaining fourteen bits are an offset, and the block adds that offset to the entry's base. Each entry holds four things: a base, a limit that acts as the segment size, a valid flag, and two permission bits, one allowing stores and one allowing instruction fetch. Reads are allowed in every valid segment.

Every request carries an access kind: read, write or fetch. The block answers one clock cycle later with a done strobe, a physical address and a two-bit fault code. A faulted access returns address zero instead of a translation. The table is loaded through a write port, and a write takes effect only when the privileged flag is set. A write without privilege leaves the table untouched and raises a denial pulse. After reset the table holds a fixed layout of four segments: code, data, shared and stack.

Top module: `seg_xlate`

## Requirements
- R1: For a request with no fault, `rsp_paddr` equals the base of entry `req_vaddr[15:14]` plus the offset `req_vaddr[13:0]`, where the offset is zero-extended to 16 bits.
- R2: After reset, entries 0..3 hold the following values. Entry 0 (code): base 0x4000, limit 0x0800, execute only. Entry 1 (data): base 0x4800, limit 0x1400, writable. Entry 2 (shared): base 0xF000, limit 0x1000, read only. Entry 3 (stack): base 0x0000, limit 0x3000, writable. All four entries are valid. With this table, 0x0240 maps to 0x4240 and 0x4050 maps to 0x4850.
- R3: An offset greater than or equal to the entry's 15-bit limit gives fault code 2 (bounds) and address 0.
- R4: An access to an entry whose valid flag is clear gives fault code 1 (invalid) and address 0.
- R5: Access kinds are encoded as 0 read, 1 write, 2 fetch, and 3 treated as read. A write to an entry without the store permission, or a fetch from an entry without the fetch permission, gives fault code 3 (protection) and address 0. A read is never a protection fault.
- R6: When several faults apply, the code reported is the invalid fault first, then the bounds fault, then the protection fault.
- R7: `rsp_done` is high in exactly the cycle after each cycle in which `req_valid` is high. Whenever `rsp_done` is low, `rsp_paddr` and `rsp_fault` are 0.
- R8: A table write with `cfg_en` and `cfg_priv` both high replaces entry `cfg_idx` at the clock edge. A request in the same cycle still sees the old entry; a request in the next cycle sees the new one.
- R9: A table write with `cfg_en` high and `cfg_priv` low changes no entry, and `cfg_denied` is high for exactly the following cycle.
- R10: While reset is asserted, and in the first cycle after it, `rsp_done`, `rsp_paddr`, `rsp_fault` and `cfg_denied` are all 0.
- R11: The sum of base and offset wraps modulo 2^16. For example, base 0xFF00 plus offset 0x0200 gives 0x0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| cfg_en | input | 1 | Table write attempt |
| cfg_priv | input | 1 | Writer is privileged |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | New base |
| cfg_limit | input | 15 | New limit (segment size) |
| cfg_valid | input | 1 | New valid flag |
| cfg_wr | input | 1 | New store permission |
| cfg_ex | input | 1 | New fetch permission |
| rsp_done | output | 1 | Result strobe, one cycle after a request |
| rsp_paddr | output | 16 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 bounds, 3 protection |
| cfg_denied | output | 1 | Pulse after a table write without privilege |

## Verification
A corrupted table entry shows up at the ports on the very next request that selects that entry. It appears as a wrong address, a fault where none is due, or a missing fault, so the bench sends requests to all four segments between table writes. A user-mode write that wrongly lands in the table is caught by the first later request to that entry. A slip in the fault priority or in the limit comparison shows only in the response to a request that sits exactly on the boundary or that breaks two rules at once. The bench drives such requests directly and also reaches them with random stimulus.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int VA_W  = 16;
  localparam int SEG_W = 2;
  localparam int OFF_W = VA_W - SEG_W;
  localparam int NSEG  = 1 << SEG_W;
  localparam int LIM_W = OFF_W + 1;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_PROT    = 2'd3
  } flt_e;

  typedef struct packed {
    logic [VA_W-1:0]  base;
    logic [LIM_W-1:0] limit;
    logic             valid;
    logic             wr_ok;
    logic             ex_ok;
  } seg_ent_t;

  function automatic seg_ent_t boot_entry(input int idx);
    seg_ent_t e;
    e.valid = 1'b1;
    case (idx)
      0:       begin e.base = 16'h4000; e.limit = 15'h0800; e.wr_ok = 1'b0; e.ex_ok = 1'b1; end
      1:       begin e.base = 16'h4800; e.limit = 15'h1400; e.wr_ok = 1'b1; e.ex_ok = 1'b0; end
      2:       begin e.base = 16'hF000; e.limit = 15'h1000; e.wr_ok = 1'b0; e.ex_ok = 1'b0; end
      default: begin e.base = 16'h0000; e.limit = 15'h3000; e.wr_ok = 1'b1; e.ex_ok = 1'b0; end
    endcase
    return e;
  endfunction
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_try,
  input  logic             wr_priv,
  input  logic [SEG_W-1:0] wr_idx,
  input  seg_ent_t         wr_ent,
  input  logic [SEG_W-1:0] rd_idx,
  output seg_ent_t         rd_ent,
  output logic             denied_o
);
  seg_ent_t ent_q [NSEG];
  logic     denied_d, denied_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic ld;
    assign ld = wr_try && wr_priv && (wr_idx == SEG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[g] <= boot_entry(g);
      else if (ld) ent_q[g] <= wr_ent;
    end
  end

  always_comb denied_d = wr_try && !wr_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) denied_q <= 1'b0;
    else        denied_q <= denied_d;
  end

  assign rd_ent   = ent_q[rd_idx];
  assign denied_o = denied_q;
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      kind,
  input  seg_ent_t        ent,
  output logic [VA_W-1:0] paddr,
  output flt_e            fault
);
  logic [OFF_W-1:0] off;
  logic             oob, prot;

  always_comb begin
    off  = vaddr[OFF_W-1:0];
    oob  = {1'b0, off} >= ent.limit;
    prot = (kind == ACC_WRITE && !ent.wr_ok) || (kind == ACC_FETCH && !ent.ex_ok);
    if (!ent.valid)  fault = FLT_INVALID;
    else if (oob)    fault = FLT_BOUNDS;
    else if (prot)   fault = FLT_PROT;
    else             fault = FLT_NONE;
    paddr = ent.base + {{SEG_W{1'b0}}, off};
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [15:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic        cfg_en,
  input  logic        cfg_priv,
  input  logic [1:0]  cfg_idx,
  input  logic [15:0] cfg_base,
  input  logic [14:0] cfg_limit,
  input  logic        cfg_valid,
  input  logic        cfg_wr,
  input  logic        cfg_ex,
  output logic        rsp_done,
  output logic [15:0] rsp_paddr,
  output logic [1:0]  rsp_fault,
  output logic        cfg_denied
);
  seg_ent_t        new_ent, cur_ent;
  logic [VA_W-1:0] sum;
  flt_e            flt;
  logic            done_d, done_q;
  logic [VA_W-1:0] pa_d, pa_q;
  flt_e            flt_d, flt_q;

  assign new_ent = '{base: cfg_base, limit: cfg_limit, valid: cfg_valid,
                     wr_ok: cfg_wr, ex_ok: cfg_ex};

  seg_table u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_try(cfg_en), .wr_priv(cfg_priv), .wr_idx(cfg_idx), .wr_ent(new_ent),
    .rd_idx(req_vaddr[VA_W-1 -: SEG_W]), .rd_ent(cur_ent),
    .denied_o(cfg_denied)
  );

  seg_check u_check (
    .vaddr(req_vaddr), .kind(req_kind), .ent(cur_ent),
    .paddr(sum), .fault(flt)
  );

  always_comb begin
    done_d = req_valid;
    flt_d  = req_valid ? flt : FLT_NONE;
    pa_d   = (req_valid && flt == FLT_NONE) ? sum : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
    end else begin
      done_q <= done_d;
      pa_q   <= pa_d;
      flt_q  <= flt_d;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_paddr = pa_q;
  assign rsp_fault = flt_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        cfg_en,
  input logic        cfg_priv,
  input logic        rsp_done,
  input logic [15:0] rsp_paddr,
  input logic [1:0]  rsp_fault,
  input logic        cfg_denied
);
  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_done);
  a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_done);
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_done |-> (rsp_fault == 2'd0 && rsp_paddr == 16'd0));
  a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (rsp_paddr == 16'd0));
  a_r9_denied_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_priv) |=> cfg_denied);
  a_r9_denied_only_user: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && !cfg_priv) |=> !cfg_denied);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cfg_en(cfg_en),
  .cfg_priv(cfg_priv), .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .cfg_denied(cfg_denied)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] req_vaddr;
  logic [1:0]  req_kind;
  logic        cfg_en, cfg_priv, cfg_valid, cfg_wr, cfg_ex;
  logic [1:0]  cfg_idx;
  logic [15:0] cfg_base;
  logic [14:0] cfg_limit;
  logic        rsp_done, cfg_denied;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [15:0] m_base [4];
  logic [14:0] m_lim  [4];
  logic        m_val [4], m_wr [4], m_ex [4];

  always #4 clk = ~clk;

  seg_xlate i_seg_xlate (.*);

  function automatic logic [1:0] exp_fault(input logic [15:0] va, input logic [1:0] k);
    int s = va[15:14];
    if (!m_val[s]) return 2'd1;
    if ({1'b0, va[13:0]} >= m_lim[s]) return 2'd2;
    if ((k == 2'd1 && !m_wr[s]) || (k == 2'd2 && !m_ex[s])) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [15:0] exp_addr(input logic [15:0] va, input logic [1:0] k);
    if (exp_fault(va, k) != 2'd0) return 16'd0;
    return m_base[va[15:14]] + {2'b00, va[13:0]};
  endfunction

  task automatic model_reset();
    m_base[0] = 16'h4000; m_lim[0] = 15'h0800; m_wr[0] = 0; m_ex[0] = 1;
    m_base[1] = 16'h4800; m_lim[1] = 15'h1400; m_wr[1] = 1; m_ex[1] = 0;
    m_base[2] = 16'hF000; m_lim[2] = 15'h1000; m_wr[2] = 0; m_ex[2] = 0;
    m_base[3] = 16'h0000; m_lim[3] = 15'h3000; m_wr[3] = 1; m_ex[3] = 0;
    for (int i = 0; i < 4; i++) m_val[i] = 1;
  endtask

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; applies one cycle of stimulus and checks the response
  task automatic step(input string tag, input logic v, input logic [15:0] va, input logic [1:0] k,
                      input logic we, input logic pv, input logic [1:0] ix, input logic [15:0] b,
                      input logic [14:0] l, input logic vl, input logic w, input logic x);
    logic [1:0]  ef;
    logic [15:0] ea;
    string t;
    req_valid = v; req_vaddr = va; req_kind = k;
    cfg_en = we; cfg_priv = pv; cfg_idx = ix; cfg_base = b; cfg_limit = l;
    cfg_valid = vl; cfg_wr = w; cfg_ex = x;
    ef = v ? exp_fault(va, k) : 2'd0;
    ea = v ? exp_addr(va, k) : 16'd0;
    @(posedge clk);
    @(negedge clk);
    if (tag != "") t = tag;
    else case (ef)
      2'd1: t = "R4";
      2'd2: t = "R3";
      2'd3: t = "R5";
      default: t = "R1";
    endcase
    check("R7", "done", {15'd0, rsp_done}, {15'd0, v});
    check(t, "fault", {14'd0, rsp_fault}, {14'd0, ef});
    check(t, "paddr", rsp_paddr, ea);
    check("R9", "denied", {15'd0, cfg_denied}, {15'd0, we && !pv});
    if (we && pv) begin
      m_base[ix] = b; m_lim[ix] = l; m_val[ix] = vl; m_wr[ix] = w; m_ex[ix] = x;
    end
  endtask

  task automatic req(input string tag, input logic [15:0] va, input logic [1:0] k);
    step(tag, 1'b1, va, k, 1'b0, 1'b0, 2'd0, 16'd0, 15'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    rst_n = 1'b0; req_valid = 0; req_vaddr = 0; req_kind = 0;
    cfg_en = 0; cfg_priv = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0;
    cfg_valid = 0; cfg_wr = 0; cfg_ex = 0;
    repeat (3) @(negedge clk);
    check("R10", "done in reset", {15'd0, rsp_done}, 16'd0);
    check("R10", "paddr in reset", rsp_paddr, 16'd0);
    check("R10", "fault in reset", {14'd0, rsp_fault}, 16'd0);
    check("R10", "denied in reset", {15'd0, cfg_denied}, 16'd0);
    rst_n = 1'b1;
    step("R10", 1'b0, 16'h0, 2'd0, 1'b0, 1'b0, 2'd0, 16'd0, 15'd0, 1'b0, 1'b0, 1'b0);

    // R2 boot layout examples
    req("R2", 16'h0240, 2'd2);
    check("R2", "0x0240", rsp_paddr, 16'h4240);
    req("R2", 16'h4050, 2'd0);
    check("R2", "0x4050", rsp_paddr, 16'h4850);
    req("R2", 16'h8FFF, 2'd0);
    req("R2", 16'hC000, 2'd1);
    // R3 boundary: last in range and first out
    req("R3", 16'h07FF, 2'd0);
    req("R3", 16'h0800, 2'd0);
    req("R3", 16'h5400, 2'd1);
    // R5 protection
    req("R5", 16'h0010, 2'd1);
    req("R5", 16'h4010, 2'd2);
    req("R5", 16'h8010, 2'd3);
    // R9 user write ignored, then entry still intact
    step("R9", 1'b1, 16'h0100, 2'd0, 1'b1, 1'b0, 2'd0, 16'h1234, 15'h0001, 1'b0, 1'b1, 1'b1);
    req("R9", 16'h0100, 2'd0);
    check("R9", "table unchanged", rsp_paddr, 16'h4100);
    // R8 privileged write; same-cycle request sees old entry
    step("R8", 1'b1, 16'h8100, 2'd0, 1'b1, 1'b1, 2'd2, 16'hFF00, 15'h4000, 1'b1, 1'b1, 1'b0);
    check("R8", "old entry same cycle", rsp_paddr, 16'hF100);
    req("R8", 16'h8100, 2'd1);
    check("R8", "new entry next cycle", rsp_paddr, 16'h0000);
    // R11 wrap
    req("R11", 16'h8200, 2'd0);
    check("R11", "wrap", rsp_paddr, 16'h0100);
    req("R11", 16'hBFFF, 2'd1);
    // R6 priority: invalid beats bounds and protection; bounds beats protection
    step("R6", 1'b0, 16'h0, 2'd0, 1'b1, 1'b1, 2'd1, 16'h2000, 15'h0000, 1'b0, 1'b0, 1'b0);
    req("R6", 16'h7FFF, 2'd2);
    check("R6", "invalid first", {14'd0, rsp_fault}, 16'd1);
    req("R6", 16'h0900, 2'd1);
    check("R6", "bounds before prot", {14'd0, rsp_fault}, 16'd2);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic v, we, pv;
      logic [15:0] va, b;
      logic [14:0] l;
      logic [1:0] r;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 8) == 0;
      pv = ($urandom % 4) != 0;
      r  = 2'($urandom);
      va = 16'($urandom);
      b  = 16'($urandom);
      case (r)
        2'd0:    l = 15'h4000;
        2'd1:    l = 15'h0000;
        default: l = 15'($urandom % 15'h4001);
      endcase
      step("", v, va, 2'($urandom), we, pv, 2'($urandom), b, l,
           ($urandom % 6) != 0, 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule